// File: doc/BRIEF.md
# Address-Encoded Configuration Register Writer

This block sits in the command interface of a flash device. It holds the 16-bit configuration register. Software loads a new value through a two-write command sequence. The value is not carried on the data bus. It is taken from the low sixteen address lines of the confirming write. The opcode of each write is on the low byte of the data bus.

The block also tracks the read mode. In array mode, every read returns the word on the array-data input. The register cannot be seen in that mode. A read-signature opcode switches to signature mode, where one fixed word offset returns the register. A read-array opcode switches back. Loading the register always leaves the block in array mode, so a new value is only seen after signature mode is entered again.

Top module: `addr_cfg_writer`

## Requirements
- R1: While reset is low and after it is released, the register holds the parameter `CFG_RESET` (default 16'hB5CF), the read mode is array mode and `rd_data` is zero.
- R2: A write with opcode 8'h60 followed by a write with opcode 8'h03 loads the register with `wr_addr[15:0]` of the second write. Other cycles may come between the two writes.
- R3: During the load, `wr_addr[23:16]` is ignored.
- R4: Only `wr_data[7:0]` is decoded as an opcode. `wr_data[15:8]` is ignored and never reaches the register.
- R5: After a load, and in array mode in general, a read returns `arr_data`.
- R6: Opcode 8'h90, written outside a pending load, selects signature mode. In that mode a read at word offset 5 (`rd_addr[7:0]`) returns the register and a read at any other offset returns zero.
- R7: If the write after 8'h60 carries any opcode other than 8'h03, the register is left unchanged and the block returns to array mode.
- R8: Opcode 8'hFF selects array mode. A lone 8'h03 with no 8'h60 before it has no effect on the register.
- R9: `rd_data` changes only in the cycle after a read strobe. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 24 | Write address; bits 15:0 carry the new value on a load |
| wr_data | input | 16 | Write data; bits 7:0 carry the opcode |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 24 | Read address; bits 7:0 select the word in signature mode |
| arr_data | input | 16 | Word from the memory array |
| rd_data | output | 16 | Read result, registered |

## Verification
Loads are tried with addresses whose upper byte is zero and with addresses whose upper byte is set. These tell apart a capture that keeps only sixteen bits from one that leaks the upper byte. Some loads carry junk in the upper data byte or use a confirm address that differs from the setup address. These show whether the value comes from the confirming write's address and not from its data. A wrong confirm code, a lone confirm and a 8'hFF exit are each followed by reads in both modes, which catches a register or mode that changed when it should not have. Reads at offset 5 and at a neighbouring offset, together with idle cycles after a read, separate a correct signature mux and output hold from an off-by-one decode or an output that is left transparent.

// File: rtl/addr_cfg_pkg.sv
// Package: shared opcodes and types for the address-encoded configuration writer.
// Assumes opcodes sit in the low byte of the write data.
package addr_cfg_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OP_SETUP   = 8'h60;
    localparam logic [OP_W-1:0] OP_CONFIRM = 8'h03;
    localparam logic [OP_W-1:0] OP_SIGREAD = 8'h90;
    localparam logic [OP_W-1:0] OP_ARRAY   = 8'hFF;

    typedef enum logic {
        MODE_ARRAY = 1'b0,
        MODE_SIG   = 1'b1
    } rmode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } cmd_state_t;

endpackage

// File: rtl/addr_cfg_decoder.sv
// Module: addr_cfg_decoder
// Decodes bus-write opcodes. It tracks the two-write load sequence and the read mode.
// It raises cap_en on a valid confirming write and presents the address-encoded value.
// Assumes one write per wr_en cycle and the opcode in wr_data[7:0].
module addr_cfg_decoder
    import addr_cfg_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cap_en,
    output logic [CFG_W-1:0]  cap_val,
    output rmode_t            mode
);

    cmd_state_t      state;
    logic [OP_W-1:0] opcode;

    // Take the opcode from the low byte of the data bus.
    assign opcode = wr_data[OP_W-1:0];

    // Signal a load only for a confirm that follows a setup.
    always_comb begin
        cap_en  = wr_en && (state == ST_PEND) && (opcode == OP_CONFIRM);
        cap_val = wr_addr[CFG_W-1:0];
    end

    // Advance the command sequence and the read mode on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            mode  <= MODE_ARRAY;
        end else if (wr_en) begin
            if (state == ST_PEND) begin
                state <= ST_IDLE;
                mode  <= MODE_ARRAY;
            end else begin
                case (opcode)
                    OP_SETUP: begin
                        state <= ST_PEND;
                        mode  <= MODE_ARRAY;
                    end
                    OP_SIGREAD: mode <= MODE_SIG;
                    OP_ARRAY:   mode <= MODE_ARRAY;
                    default:    mode <= mode;
                endcase
            end
        end
    end

    AST_PEND_EXITS_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND && wr_en) |=> (state == ST_IDLE && mode == MODE_ARRAY)); // R7

    AST_SIG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_en && opcode == OP_SIGREAD) |=> (mode == MODE_SIG)); // R6

endmodule

// File: rtl/addr_cfg_store.sv
// Module: addr_cfg_store
// Holds the configuration register. It loads the captured value on cap_en.
// Assumes cap_en comes from the decoder and lasts one cycle per load.
module addr_cfg_store #(
    parameter int          CFG_W     = 16,
    parameter logic [15:0] CFG_RESET = 16'hB5CF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [CFG_W-1:0] cap_val,
    output logic [CFG_W-1:0] cfg_q
);

    // Load a new value on capture and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET[CFG_W-1:0];
        else if (cap_en)
            cfg_q <= cap_val;
    end

    AST_CFG_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $past(cap_en)); // R8

    AST_CFG_LOADS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (cfg_q == $past(cap_val))); // R2

endmodule

// File: rtl/addr_cfg_readmux.sv
// Module: addr_cfg_readmux
// Registered read path. In array mode it returns array data. In signature mode
// it returns the register at one fixed word offset and zero at every other offset.
// Assumes arr_data is valid in the cycle of rd_en.
module addr_cfg_readmux
    import addr_cfg_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 16,
    parameter int CFG_W   = 16,
    parameter int SIG_W   = 8,
    parameter int CFG_OFS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [CFG_W-1:0]  cfg_q,
    input  rmode_t            mode,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [SIG_W-1:0] OFS_CODE = SIG_W'(CFG_OFS);

    logic [DATA_W-1:0] next_word;
    logic              ofs_hit;

    // Pick the word that the current mode and offset select.
    always_comb begin
        ofs_hit = (rd_addr[SIG_W-1:0] == OFS_CODE);
        if (mode == MODE_ARRAY)
            next_word = arr_data;
        else if (ofs_hit)
            next_word = DATA_W'(cfg_q);
        else
            next_word = '0;
    end

    // Update the output only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= next_word;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R9

    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == MODE_ARRAY) |=> (rd_data == $past(arr_data))); // R5

    AST_SIG_CFG_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == MODE_SIG && rd_addr[SIG_W-1:0] == OFS_CODE)
        |=> (rd_data == DATA_W'($past(cfg_q)))); // R6

endmodule

// File: rtl/addr_cfg_writer.sv
// Module: addr_cfg_writer (top)
// Command-interface slice that loads the configuration register from the address
// lines through a setup/confirm write pair and serves reads in array or signature mode.
// Assumes synchronous single-cycle bus strobes and an active-low synchronous reset.
module addr_cfg_writer
    import addr_cfg_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          DATA_W    = 16,
    parameter int          CFG_W     = 16,
    parameter int          SIG_W     = 8,
    parameter int          CFG_OFS   = 5,
    parameter logic [15:0] CFG_RESET = 16'hB5CF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic             cap_en;
    logic [CFG_W-1:0] cap_val;
    logic [CFG_W-1:0] cfg_q;
    rmode_t           mode;

    addr_cfg_decoder #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CFG_W  (CFG_W)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cap_en  (cap_en),
        .cap_val (cap_val),
        .mode    (mode)
    );

    addr_cfg_store #(
        .CFG_W     (CFG_W),
        .CFG_RESET (CFG_RESET)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .cap_val (cap_val),
        .cfg_q   (cfg_q)
    );

    addr_cfg_readmux #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CFG_W   (CFG_W),
        .SIG_W   (SIG_W),
        .CFG_OFS (CFG_OFS)
    ) u_rmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .arr_data (arr_data),
        .cfg_q    (cfg_q),
        .mode     (mode),
        .rd_data  (rd_data)
    );

    AST_LOAD_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (cfg_q == $past(wr_addr[CFG_W-1:0]))); // R3

    AST_LOAD_LEAVES_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (mode == MODE_ARRAY)); // R5

endmodule

// File: tb/addr_cfg_writer_tb.sv
// Bench for addr_cfg_writer: a table of load vectors walked by one loop, then directed tests.
module addr_cfg_writer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [23:0] rd_addr = '0;
    logic [15:0] arr_data = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] model_cfg;

    always #5 clk = ~clk;

    addr_cfg_writer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .arr_data (arr_data),
        .rd_data  (rd_data)
    );

    // Each vector: {setup address, confirm address, confirm data word}.
    localparam int NV = 6;
    localparam logic [63:0] VEC [NV] = '{
        {24'h00_1234, 24'h00_1234, 16'h0003},
        {24'hFF_A5C3, 24'hFF_A5C3, 16'h0003},
        {24'h00_0000, 24'h3C_7E81, 16'hAB03},
        {24'h00_FFFF, 24'h00_FFFF, 16'h0090},
        {24'h12_0000, 24'h12_0000, 16'h0003},
        {24'h00_4444, 24'h80_9999, 16'h0060}
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic bus_read(input logic [23:0] a, output logic [15:0] q);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] q;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held and right after release
        check("R1 rd_data in reset", rd_data, 16'h0000);
        rst_n = 1'b1;
        model_cfg = 16'hB5CF;
        arr_data = 16'hC0DE;
        bus_read(24'h000005, q);
        check("R1 array mode after reset", q, 16'hC0DE);
        bus_write(24'h0, 16'h0090);
        bus_read(24'h000005, q);
        check("R1 reset value", q, 16'hB5CF);
        bus_write(24'h0, 16'h00FF);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            logic [23:0] sa, ca;
            logic [15:0] cd;
            sa = VEC[i][63:40]; ca = VEC[i][39:16]; cd = VEC[i][15:0];
            bus_write(sa, 16'h0060);
            @(negedge clk);
            bus_write(ca, cd);
            if (cd[7:0] == 8'h03) model_cfg = ca[15:0];
            arr_data = 16'h5A00 ^ 16'(i);
            bus_read(24'h000005, q);
            check("R5 array read after load", q, 16'h5A00 ^ 16'(i));
            bus_write(24'h0, 16'h0090);
            bus_read(24'hFF0005, q);
            check("R2 R3 R4 R7 signature cfg word", q, model_cfg);
            bus_read(24'h000004, q);
            check("R6 other offset reads zero", q, 16'h0000);
            bus_write(24'h0, 16'h00FF);
        end

        // R8: lone confirm has no effect; 0xFF returns to array mode
        bus_write(24'h00_0F0F, 16'h0003);
        bus_write(24'h0, 16'h0090);
        bus_read(24'h000005, q);
        check("R8 lone confirm ignored", q, model_cfg);
        bus_write(24'h0, 16'h00FF);
        arr_data = 16'h1357;
        bus_read(24'h000005, q);
        check("R8 array mode after FF", q, 16'h1357);

        // R9: output holds without a read strobe
        arr_data = 16'hEEEE;
        repeat (3) @(negedge clk);
        check("R9 rd_data holds", rd_data, 16'h1357);

        // R1: reset again restores the default value
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1 rd_data cleared by reset", rd_data, 16'h0000);
        rst_n = 1'b1;
        bus_write(24'h0, 16'h0090);
        bus_read(24'h000005, q);
        check("R1 default restored", q, 16'hB5CF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule